// File: doc/BRIEF.md
# Load/Store Data Watchpoint Comparator

This block observes the load/store transfers a processor issues and decides, for each instruction, whether any of its transfers touched a programmed address with a programmed data pattern. Two address comparators can each test equal, not-equal, greater-than or less-than. Either the first comparator works alone, or both are combined into a range. The address comparison drops the low address bits that the access size makes meaningless. A byte or half-word can therefore be caught even when the code reads it with a wider load. The data comparison works on byte lanes. A lane-enable mask selects which lanes take part, and a mode setting (word, half-word or byte) decides how the enabled lanes combine into a data hit.

Hits are not reported when they occur. Each tracked instruction tag keeps a sticky pending bit. That bit collects every hit from the instruction's transfers. It is turned into exactly one event when the retire port names the tag. Several retire lanes may name different tags in the same cycle, and each lane then reports its own event. Every reported event decrements a loadable 16-bit counter. When a decrement brings the counter to zero, the block emits a one-cycle terminal-count pulse. A flush input discards all pending hits.

Top module: `wp_data_watch`

## Requirements
- R1: Address matching ignores low bits by access size: for size code 10 (word) and 11 bits [1:0] of both the transfer address and the reference address are excluded; for 01 (half-word) only bit 0 is excluded; for 00 (byte) every bit is compared.
- R2: Each address comparator applies its 2-bit operation as an unsigned test of the masked transfer address against the masked reference address: 00 equal, 01 not equal, 10 transfer greater, 11 transfer less.
- R3: With cfg_range_en at 1 the address hit is the AND of comparators A and B; with it at 0 only comparator A decides.
- R4: Byte lane i is data bits [8i+7:8i]. Only lanes whose cfg_lane_en bit is 1 take part in the data match. In word mode (cfg_mode 10 or 11), every enabled lane must be equal, and an all-zero mask matches any data.
- R5: In half-word mode (cfg_mode 01), a data hit needs one lane pair (lanes 1:0 or lanes 3:2) with at least one enabled lane and all of its enabled lanes equal. In byte mode (cfg_mode 00), a data hit needs any single enabled lane to be equal. With no enabled lane, neither mode hits.
- R6: Any number of hits carrying the same tag before that tag retires produce one event and one counter decrement.
- R7: When ret_valid[k] names a tag with a pending hit, ev_fire[k] is high for exactly the one cycle after the retire. A hit that arrives in the retire cycle itself also counts. The retire clears the tag's pending bit. A retire may only name a tag whose last transfer has been seen, or that had no transfers.
- R8: Retire lanes that report events in the same cycle each raise their ev_fire bit, and the counter drops by the number of those events.
- R9: A cycle with flush at 1 clears every pending bit, drops any hit that arrives in that cycle, and reports no event for a retire in that cycle.
- R10: cfg_cnt_load loads cfg_cnt_value into the counter and takes priority over a decrement in the same cycle. Decrements saturate at zero. ev_tc pulses for one cycle, together with the new count, only when a decrement takes a non-zero count to zero.
- R11: After reset the counter is 0, ev_fire is 0, ev_tc is 0, and no tag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_a | input | 32 | Reference address of comparator A |
| cfg_addr_b | input | 32 | Reference address of comparator B |
| cfg_op_a | input | 2 | Operation of comparator A |
| cfg_op_b | input | 2 | Operation of comparator B |
| cfg_range_en | input | 1 | Combine A and B into a range |
| cfg_data | input | 32 | Data match value placed in its bus lanes |
| cfg_lane_en | input | 4 | Per-lane participation mask |
| cfg_mode | input | 2 | Data match mode: 00 byte, 01 half-word, 10 word |
| cfg_cnt_load | input | 1 | Load the event counter |
| cfg_cnt_value | input | 16 | Counter load value |
| xfer_valid | input | 1 | Transfer present this cycle |
| xfer_addr | input | 32 | Transfer address |
| xfer_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| xfer_data | input | 32 | Transfer data as seen on the bus lanes |
| xfer_tag | input | 3 | Instruction tag of the transfer |
| xfer_last | input | 1 | Last transfer of the instruction |
| flush | input | 1 | Discard all pending hits |
| ret_valid | input | 2 | Retire strobe per retire lane |
| ret_tag | input | 6 | Retiring tag per lane, lane k at bits [3k+2:3k] |
| ev_fire | output | 2 | Watchpoint event per retire lane |
| ev_count | output | 16 | Event counter value |
| ev_tc | output | 1 | Terminal-count pulse |

## Verification
A matching transfer can arrive in the very cycle its own tag retires. The same cycle can also decide whether the counter reaches zero. The bench sets up both collisions. It drives a hitting transfer and the retire of that tag together and expects the event one cycle later, with the pending bit already cleared. It retires two pending tags on separate lanes in one cycle while the count is 2, and expects both event bits, a count of 0 and a single ev_tc pulse that is gone on the next cycle. A third collision puts a counter load in the same cycle as a reported event. That case must show the event but keep the loaded value, with no pulse.

// File: rtl/wp_pkg.sv
// Shared encodings for the load/store data watchpoint.
// Assumes 2-bit codes on all configuration and transfer ports.
package wp_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_NE = 2'b01,
        CMP_GT = 2'b10,
        CMP_LT = 2'b11
    } cmp_op_e;

    localparam int unsigned N_ADDR_CMP = 2;
endpackage

// File: rtl/wp_addr_cmp.sv
// Single address comparator. Removes the address bits that the access size
// leaves undefined (on both sides), then applies an unsigned relation.
// Assumes reference addresses are aligned to the access size for range use.
module wp_addr_cmp
    import wp_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] ref_addr,
    input  logic [1:0]    op,
    output logic          hit
);
    logic [AW-1:0] keep;
    logic [AW-1:0] acc_m;
    logic [AW-1:0] ref_m;

    // Build the low-bit mask from the access size.
    always_comb begin
        keep = '1;
        case (acc_size_e'(acc_size))
            ACC_HALF: keep[0] = 1'b0;
            ACC_WORD, ACC_RSVD: keep[1:0] = 2'b00;
            default: ;
        endcase
    end

    assign acc_m = acc_addr & keep;
    assign ref_m = ref_addr & keep;

    // Evaluate the programmed relation on the masked addresses.
    always_comb begin
        case (cmp_op_e'(op))
            CMP_EQ:  hit = (acc_m == ref_m);
            CMP_NE:  hit = (acc_m != ref_m);
            CMP_GT:  hit = (acc_m > ref_m);
            default: hit = (acc_m < ref_m);
        endcase
    end
endmodule

// File: rtl/wp_data_cmp.sv
// Byte-lane data comparator. Lanes are compared individually. The mode then
// combines enabled lanes: all of them (word), either lane pair (half-word),
// or any single lane (byte). Assumes LANES is even.
module wp_data_cmp
    import wp_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES*8-1:0] data,
    input  logic [LANES*8-1:0] ref_data,
    input  logic [LANES-1:0]   lane_en,
    input  logic [1:0]         mode,
    output logic               hit
);
    localparam int unsigned NPAIR = LANES / 2;

    logic [LANES-1:0] lane_eq;
    logic [LANES-1:0] lane_pass;
    logic [LANES-1:0] lane_hit;
    logic [NPAIR-1:0] pair_hit;

    // Per-lane equality and its masked forms.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_eq[i]   = (data[8*i +: 8] == ref_data[8*i +: 8]);
        assign lane_pass[i] = lane_eq[i] | ~lane_en[i];
        assign lane_hit[i]  = lane_eq[i] & lane_en[i];
    end

    // A lane pair hits when it has an enabled lane and all enabled lanes match.
    for (genvar h = 0; h < NPAIR; h++) begin : g_pair
        assign pair_hit[h] = (|lane_en[2*h +: 2]) & (&lane_pass[2*h +: 2]);
    end

    // Combine lanes according to the match mode.
    always_comb begin
        case (acc_size_e'(mode))
            ACC_BYTE: hit = |lane_hit;
            ACC_HALF: hit = |pair_hit;
            default:  hit = &lane_pass;
        endcase
    end

    // R5
    sub_word_needs_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (mode == 2'b00 || mode == 2'b01)) |-> (lane_en != '0));
endmodule

// File: rtl/wp_tracker.sv
// Per-tag sticky hit tracking and retire-time event generation.
// A hit sets the pending bit of its tag. A retire turns the pending bit, or a
// hit in the same cycle, into one event and clears the bit. Flush clears all
// bits and silences that cycle. Assumes retire lanes in one cycle name
// distinct tags.
module wp_tracker #(
    parameter int unsigned TAGW = 3,
    parameter int unsigned NRET = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_valid,
    input  logic                 xfer_hit,
    input  logic [TAGW-1:0]      xfer_tag,
    input  logic                 xfer_last,
    input  logic                 flush,
    input  logic [NRET-1:0]      ret_valid,
    input  logic [NRET*TAGW-1:0] ret_tag,
    output logic [NRET-1:0]      ev_next,
    output logic [NRET-1:0]      ev_fire
);
    localparam int unsigned NTAG = 1 << TAGW;

    logic [NTAG-1:0] pend_q, pend_d;
    logic [NTAG-1:0] open_q, open_d;
    logic [NTAG-1:0] ret_sel;

    // Decode which tags retire this cycle.
    always_comb begin
        ret_sel = '0;
        for (int k = 0; k < int'(NRET); k++) begin
            if (ret_valid[k]) ret_sel[ret_tag[k*TAGW +: TAGW]] = 1'b1;
        end
    end

    // Form this cycle's events, including a same-cycle hit of the retiring tag.
    always_comb begin
        for (int k = 0; k < int'(NRET); k++) begin
            ev_next[k] = ret_valid[k] && !flush &&
                         (pend_q[ret_tag[k*TAGW +: TAGW]] ||
                          (xfer_hit && xfer_tag == ret_tag[k*TAGW +: TAGW]));
        end
    end

    // Next pending and open state for every tag.
    for (genvar t = 0; t < NTAG; t++) begin : g_tag
        logic mine;
        assign mine = (xfer_tag == TAGW'(t));
        assign pend_d[t] = flush      ? 1'b0 :
                           ret_sel[t] ? 1'b0 :
                           (pend_q[t] | (xfer_hit & mine));
        assign open_d[t] = flush               ? 1'b0 :
                           (xfer_valid && mine) ? !xfer_last :
                           ret_sel[t]           ? 1'b0 : open_q[t];
    end

    // State and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            open_q  <= '0;
            ev_fire <= '0;
        end else begin
            pend_q  <= pend_d;
            open_q  <= open_d;
            ev_fire <= ev_next;
        end
    end

    for (genvar k = 0; k < NRET; k++) begin : g_chk
        // R7
        fire_after_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_fire[k] |-> $past(ret_valid[k]));
        // R7
        retire_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid[k] |-> (!open_q[ret_tag[k*TAGW +: TAGW]] ||
                (xfer_valid && xfer_last && xfer_tag == ret_tag[k*TAGW +: TAGW])));
    end

    // R9
    flush_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (ev_fire == '0));
endmodule

// File: rtl/wp_event_counter.sv
// Loadable down-counter of reported events with a terminal-count pulse.
// Each cycle it subtracts the number of events, saturating at zero. A load
// wins over a decrement. The pulse marks a decrement that reaches zero.
module wp_event_counter #(
    parameter int unsigned CW   = 16,
    parameter int unsigned NRET = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NRET-1:0] ev_next,
    input  logic            load,
    input  logic [CW-1:0]   load_val,
    output logic [CW-1:0]   count,
    output logic            tc
);
    logic [CW-1:0] n_ev;

    // Count the events of this cycle.
    always_comb begin
        n_ev = '0;
        for (int k = 0; k < int'(NRET); k++) n_ev = n_ev + CW'(ev_next[k]);
    end

    // Update the count and terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            tc    <= 1'b0;
        end else if (load) begin
            count <= load_val;
            tc    <= 1'b0;
        end else if (n_ev != '0) begin
            count <= (count <= n_ev) ? '0 : count - n_ev;
            tc    <= (count != '0) && (count <= n_ev);
        end else begin
            tc    <= 1'b0;
        end
    end

    // R10
    tc_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (count == '0 && $past(count) != '0));
    // R10
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (count == $past(load_val)));
    // R8
    only_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> (count <= $past(count)));
endmodule

// File: rtl/wp_data_watch.sv
// Top of the load/store data watchpoint. Two address comparators (alone or as
// a range) and a lane comparator qualify each transfer. Hits are merged per
// instruction tag and reported at retire, and every event is counted.
// Assumes configuration is stable while transfers of interest are in flight.
module wp_data_watch
    import wp_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned TAGW = 3,
    parameter int unsigned NRET = 2,
    parameter int unsigned CW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        cfg_addr_a,
    input  logic [AW-1:0]        cfg_addr_b,
    input  logic [1:0]           cfg_op_a,
    input  logic [1:0]           cfg_op_b,
    input  logic                 cfg_range_en,
    input  logic [DW-1:0]        cfg_data,
    input  logic [DW/8-1:0]      cfg_lane_en,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_cnt_load,
    input  logic [CW-1:0]        cfg_cnt_value,
    input  logic                 xfer_valid,
    input  logic [AW-1:0]        xfer_addr,
    input  logic [1:0]           xfer_size,
    input  logic [DW-1:0]        xfer_data,
    input  logic [TAGW-1:0]      xfer_tag,
    input  logic                 xfer_last,
    input  logic                 flush,
    input  logic [NRET-1:0]      ret_valid,
    input  logic [NRET*TAGW-1:0] ret_tag,
    output logic [NRET-1:0]      ev_fire,
    output logic [CW-1:0]        ev_count,
    output logic                 ev_tc
);
    localparam int unsigned LANES = DW / 8;

    logic [AW-1:0]         cmp_ref [N_ADDR_CMP];
    logic [1:0]            cmp_op  [N_ADDR_CMP];
    logic [N_ADDR_CMP-1:0] cmp_hit;
    logic                  addr_hit;
    logic                  data_hit;
    logic                  xfer_hit;
    logic [NRET-1:0]       ev_next;

    assign cmp_ref[0] = cfg_addr_a;
    assign cmp_ref[1] = cfg_addr_b;
    assign cmp_op[0]  = cfg_op_a;
    assign cmp_op[1]  = cfg_op_b;

    // One address comparator per reference.
    for (genvar c = 0; c < N_ADDR_CMP; c++) begin : g_acmp
        wp_addr_cmp #(.AW(AW)) i_acmp (
            .acc_addr (xfer_addr),
            .acc_size (xfer_size),
            .ref_addr (cmp_ref[c]),
            .op       (cmp_op[c]),
            .hit      (cmp_hit[c])
        );
    end

    // Single comparator or range of two.
    assign addr_hit = cfg_range_en ? (cmp_hit[0] & cmp_hit[1]) : cmp_hit[0];

    wp_data_cmp #(.LANES(LANES)) i_dcmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .data     (xfer_data),
        .ref_data (cfg_data),
        .lane_en  (cfg_lane_en),
        .mode     (cfg_mode),
        .hit      (data_hit)
    );

    // A transfer hits when present and both comparisons agree.
    assign xfer_hit = xfer_valid & addr_hit & data_hit;

    wp_tracker #(.TAGW(TAGW), .NRET(NRET)) i_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_valid (xfer_valid),
        .xfer_hit   (xfer_hit),
        .xfer_tag   (xfer_tag),
        .xfer_last  (xfer_last),
        .flush      (flush),
        .ret_valid  (ret_valid),
        .ret_tag    (ret_tag),
        .ev_next    (ev_next),
        .ev_fire    (ev_fire)
    );

    wp_event_counter #(.CW(CW), .NRET(NRET)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_next  (ev_next),
        .load     (cfg_cnt_load),
        .load_val (cfg_cnt_value),
        .count    (ev_count),
        .tc       (ev_tc)
    );

    // R3
    range_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_range_en && addr_hit) |-> (cmp_hit == 2'b11));
endmodule

// File: tb/test_wp_data_watch.sv
// Directed bench: one task per scenario, each checking its own results.
module test_wp_data_watch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_addr_a, cfg_addr_b, cfg_data;
    logic [1:0]  cfg_op_a, cfg_op_b, cfg_mode;
    logic        cfg_range_en, cfg_cnt_load;
    logic [3:0]  cfg_lane_en;
    logic [15:0] cfg_cnt_value;
    logic        xfer_valid, xfer_last, flush;
    logic [31:0] xfer_addr, xfer_data;
    logic [1:0]  xfer_size;
    logic [2:0]  xfer_tag;
    logic [1:0]  ret_valid;
    logic [5:0]  ret_tag;
    logic [1:0]  ev_fire;
    logic [15:0] ev_count;
    logic        ev_tc;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_data_watch i_wp_data_watch (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_a(cfg_addr_a), .cfg_addr_b(cfg_addr_b),
        .cfg_op_a(cfg_op_a), .cfg_op_b(cfg_op_b), .cfg_range_en(cfg_range_en),
        .cfg_data(cfg_data), .cfg_lane_en(cfg_lane_en), .cfg_mode(cfg_mode),
        .cfg_cnt_load(cfg_cnt_load), .cfg_cnt_value(cfg_cnt_value),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_size(xfer_size),
        .xfer_data(xfer_data), .xfer_tag(xfer_tag), .xfer_last(xfer_last),
        .flush(flush), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .ev_fire(ev_fire), .ev_count(ev_count), .ev_tc(ev_tc)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic idle();
        xfer_valid = 0; xfer_addr = 0; xfer_size = 0; xfer_data = 0;
        xfer_tag = 0; xfer_last = 0; flush = 0; ret_valid = 0; ret_tag = 0;
        cfg_cnt_load = 0; cfg_cnt_value = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic put_x(input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] d, input logic [2:0] tg, input logic lst);
        xfer_valid = 1; xfer_addr = a; xfer_size = sz;
        xfer_data = d; xfer_tag = tg; xfer_last = lst;
    endtask

    task automatic put_r(input int lane, input logic [2:0] tg);
        ret_valid[lane] = 1'b1;
        ret_tag[lane*3 +: 3] = tg;
    endtask

    task automatic dec(input int n);
        exp_cnt = (exp_cnt <= n) ? 0 : exp_cnt - n;
    endtask

    task automatic retire_chk(input logic [2:0] tg, input logic exp_ev, input string what);
        put_r(0, tg);
        tick();
        chk({30'd0, ev_fire}, {31'd0, exp_ev}, what);
        if (exp_ev) dec(1);
        chk({16'd0, ev_count}, exp_cnt, what);
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] d, input logic exp_ev, input string what);
        put_x(a, sz, d, 3'd0, 1'b1);
        tick();
        retire_chk(3'd0, exp_ev, what);
    endtask

    task automatic load_cnt(input logic [15:0] v);
        cfg_cnt_load = 1; cfg_cnt_value = v;
        tick();
        exp_cnt = v;
        chk({16'd0, ev_count}, exp_cnt, "R10 load");
    endtask

    task automatic base_cfg();
        cfg_addr_a = 32'h1000; cfg_addr_b = 32'h0; cfg_op_a = 2'b00; cfg_op_b = 2'b00;
        cfg_range_en = 0; cfg_data = 32'h11223344; cfg_lane_en = 4'hF; cfg_mode = 2'b10;
    endtask

    task automatic t_reset();
        chk({16'd0, ev_count}, 0, "R11 count");
        chk({30'd0, ev_fire}, 0, "R11 fire");
        chk({31'd0, ev_tc}, 0, "R11 tc");
        retire_chk(3'd0, 1'b0, "R11 nothing pending");
    endtask

    task automatic t_size_mask();
        base_cfg();
        load_cnt(16'd100);
        probe(32'h1003, 2'b10, 32'h11223344, 1, "R1 word ignores [1:0]");
        probe(32'h1003, 2'b00, 32'h11223344, 0, "R1 byte compares all bits");
        probe(32'h1001, 2'b01, 32'h11223344, 1, "R1 half ignores bit0");
        probe(32'h1002, 2'b01, 32'h11223344, 0, "R1 half keeps bit1");
    endtask

    task automatic t_ops();
        base_cfg();
        cfg_op_a = 2'b01;
        probe(32'h2000, 2'b10, 32'h11223344, 1, "R2 not-equal differs");
        probe(32'h1000, 2'b10, 32'h11223344, 0, "R2 not-equal same");
        cfg_op_a = 2'b10;
        probe(32'h2000, 2'b10, 32'h11223344, 1, "R2 greater");
        probe(32'h0800, 2'b10, 32'h11223344, 0, "R2 greater fails");
        cfg_op_a = 2'b11;
        probe(32'h0800, 2'b10, 32'h11223344, 1, "R2 less");
    endtask

    task automatic t_range();
        base_cfg();
        cfg_addr_a = 32'h0FFC; cfg_op_a = 2'b10;
        cfg_addr_b = 32'h2000; cfg_op_b = 2'b11; cfg_range_en = 1;
        probe(32'h1800, 2'b10, 32'h11223344, 1, "R3 inside range");
        probe(32'h2000, 2'b10, 32'h11223344, 0, "R3 upper bound");
        probe(32'h0FFC, 2'b10, 32'h11223344, 0, "R3 lower bound");
        probe(32'h3000, 2'b10, 32'h11223344, 0, "R3 above range");
        cfg_range_en = 0;
        probe(32'h3000, 2'b10, 32'h11223344, 1, "R3 A alone");
    endtask

    task automatic t_lanes_word();
        base_cfg();
        cfg_lane_en = 4'b0011; cfg_data = 32'h00003344;
        probe(32'h1000, 2'b10, 32'hAAAA3344, 1, "R4 masked lanes ignored");
        probe(32'h1000, 2'b10, 32'hAAAA3345, 0, "R4 enabled lane differs");
        cfg_lane_en = 4'b0000;
        probe(32'h1000, 2'b10, 32'h12345678, 1, "R4 empty mask word");
    endtask

    task automatic t_sub_word();
        base_cfg();
        cfg_mode = 2'b01; cfg_data = 32'hBEEF0000; cfg_lane_en = 4'b1100;
        probe(32'h1000, 2'b10, 32'hBEEF1234, 1, "R5 half in upper pair");
        probe(32'h1000, 2'b10, 32'h1234BEEF, 0, "R5 half in wrong pair");
        cfg_mode = 2'b00; cfg_data = 32'h00550000; cfg_lane_en = 4'b0100;
        probe(32'h1000, 2'b10, 32'h12553456, 1, "R5 byte lane 2");
        probe(32'h1000, 2'b10, 32'h55000000, 0, "R5 byte wrong lane");
        cfg_lane_en = 4'b0000; cfg_data = 32'h0;
        probe(32'h1000, 2'b10, 32'h0, 0, "R5 byte empty mask");
    endtask

    task automatic t_merge();
        base_cfg();
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd2, 0); tick();
        put_x(32'h1004, 2'b10, 32'h00000000, 3'd2, 0); tick();
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd2, 1); tick();
        retire_chk(3'd2, 1, "R6 multiple hits one event");
        cfg_mode = 2'b00; cfg_data = 32'h55555555;
        probe(32'h1000, 2'b10, 32'h55555555, 1, "R6 four matching bytes one event");
    endtask

    task automatic t_bypass();
        base_cfg();
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd3, 1);
        put_r(0, 3'd3);
        tick();
        chk({30'd0, ev_fire}, 32'd1, "R7 same-cycle hit reported");
        dec(1);
        chk({16'd0, ev_count}, exp_cnt, "R7 same-cycle count");
        tick();
        chk({30'd0, ev_fire}, 0, "R7 one-cycle pulse");
        retire_chk(3'd3, 0, "R7 pending cleared by retire");
    endtask

    task automatic t_dual();
        base_cfg();
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd4, 1); tick();
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd5, 1); tick();
        put_r(0, 3'd4); put_r(1, 3'd5); tick();
        chk({30'd0, ev_fire}, 32'd3, "R8 both lanes fire");
        dec(2);
        chk({16'd0, ev_count}, exp_cnt, "R8 counter minus two");
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd1, 1); tick();
        put_r(0, 3'd0); put_r(1, 3'd1); tick();
        chk({30'd0, ev_fire}, 32'd2, "R8 lane 1 only");
        dec(1);
        chk({16'd0, ev_count}, exp_cnt, "R8 counter minus one");
    endtask

    task automatic t_flush();
        base_cfg();
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd6, 1); tick();
        flush = 1; tick();
        retire_chk(3'd6, 0, "R9 flush clears pending");
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd6, 1); tick();
        flush = 1; put_r(0, 3'd6); tick();
        chk({30'd0, ev_fire}, 0, "R9 retire in flush cycle");
        chk({16'd0, ev_count}, exp_cnt, "R9 count unchanged");
        retire_chk(3'd6, 0, "R9 still cleared");
        flush = 1; put_x(32'h1000, 2'b10, 32'h11223344, 3'd5, 1); tick();
        retire_chk(3'd5, 0, "R9 hit in flush cycle dropped");
    endtask

    task automatic t_counter();
        base_cfg();
        load_cnt(16'd2);
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd1, 1); tick();
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd2, 1); tick();
        put_r(0, 3'd1); put_r(1, 3'd2); tick();
        chk({16'd0, ev_count}, 0, "R10 reaches zero");
        chk({31'd0, ev_tc}, 1, "R10 tc on zero");
        exp_cnt = 0;
        tick();
        chk({31'd0, ev_tc}, 0, "R10 tc one cycle");
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd0, 1); tick();
        put_r(0, 3'd0); tick();
        chk({30'd0, ev_fire}, 1, "R10 event at zero");
        chk({16'd0, ev_count}, 0, "R10 saturates");
        chk({31'd0, ev_tc}, 0, "R10 no tc when already zero");
        load_cnt(16'd1);
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd0, 1); tick();
        put_r(0, 3'd0); tick();
        chk({31'd0, ev_tc}, 1, "R10 tc from one");
        put_x(32'h1000, 2'b10, 32'h11223344, 3'd0, 1); tick();
        cfg_cnt_load = 1; cfg_cnt_value = 16'd7; put_r(0, 3'd0); tick();
        chk({30'd0, ev_fire}, 1, "R10 event during load");
        chk({16'd0, ev_count}, 7, "R10 load wins");
        chk({31'd0, ev_tc}, 0, "R10 no tc on load");
    endtask

    initial begin
        rst_n = 0;
        idle();
        base_cfg();
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_size_mask();
        t_ops();
        t_range();
        t_lanes_word();
        t_sub_word();
        t_merge();
        t_bypass();
        t_dual();
        t_flush();
        t_counter();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule